// File: doc/BRIEF.md
# Fan PWM Channel with Edge-Point Compare

This block produces one fan drive waveform. The input clock goes through two prescalers in series. The first divides by a power of two. The second divides by a linear count. Each prescaled tick advances an 8-bit cycle counter. The output goes to its active level when the counter reaches a programmed rise point. It returns to idle when the counter reaches a programmed fall point. Putting the rise point at zero makes the fall point the duty setting, in ticks, from 0 up to the period.

A configuration interface drives the duty word and the control inputs as plain levels. The output stage can invert the waveform, run as an open-drain pin through a separate enable, or hold a static active level. Period and point updates are normally held until the cycle counter wraps, so every cycle is complete and glitch free. An external watchdog event can replace either the rise point or the fall point with a fallback value from the duty word. This lets a fan fall back to a safe speed without software.

Top module: `fan_pwm_chan`

## Requirements
- R1: The power-of-two prescaler takes a 4-bit code n on `cfg_exp` and divides the clock by 2^n. Code 0 passes every cycle.
- R2: The linear prescaler follows the power-of-two stage. It takes an 8-bit code m on `cfg_lin` and divides by m+1. The total tick interval is 2^n*(m+1) clocks, and code 0xFF gives a factor of 256.
- R3: The duty word is laid out as period [31:24], fallback point [23:16], fall point [15:8] and rise point [7:0]. One cycle lasts period+1 ticks. The output is active from the tick where the counter equals the rise point until the tick where it equals the fall point. When the rise point is after the fall point, the active time runs across the wrap.
- R4: When the rise and fall points are equal, the output stays inactive for the whole cycle.
- R5: The channel runs only when both `cfg_clk_en` and `cfg_pin_en` are 1. Otherwise the prescalers and the counter are held at zero, and `pwm_o` rests at its inactive level, which is 1 when `cfg_inv` is set.
- R6: With `cfg_inv` set, `pwm_o` is the complement of the waveform. With `cfg_od` set, `pwm_oe` is 1 only while `pwm_o` is 0. With `cfg_od` clear, `pwm_oe` stays 1.
- R7: With `cfg_sync_dis` at 0, a change to the period, rise or fall point takes effect only after the counter next wraps, so the cycle in progress finishes with the old values.
- R8: With `cfg_sync_dis` at 1, duty word changes take effect within a clock. This can change the cycle in progress.
- R9: With `cfg_force` set on a running channel, the output holds the active level.
- R10: A pulse on `wd_evt` while `cfg_wd_en` is 1 replaces a compare point with duty bits [23:16]. It replaces the rise point when `cfg_wd_sel` is 0 and the fall point when it is 1. The replacement lasts until the channel is disabled. The event is ignored when `cfg_wd_en` is 0.
- R11: After reset with the channel disabled, `pwm_o` is 0 and `pwm_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_duty | input | 32 | Period, fallback point, fall point and rise point |
| cfg_exp | input | EXP_W | Power-of-two prescaler code |
| cfg_lin | input | LIN_W | Linear prescaler code |
| cfg_clk_en | input | 1 | Clock enable for the channel |
| cfg_pin_en | input | 1 | Pin enable for the channel |
| cfg_inv | input | 1 | Invert the output |
| cfg_od | input | 1 | Open-drain mode |
| cfg_force | input | 1 | Hold the active level while running |
| cfg_sync_dis | input | 1 | Apply duty changes at once instead of at wrap |
| cfg_wd_en | input | 1 | Allow the watchdog fallback load |
| cfg_wd_sel | input | 1 | Fallback target: 0 rise point, 1 fall point |
| wd_evt | input | 1 | Watchdog event |
| pwm_o | output | 1 | Output level |
| pwm_oe | output | 1 | Output driver enable |

## Verification
The bench measures the active and period times of each pulse and compares them with values derived from the divider codes and compare points. It covers the largest linear code and a rise point after the fall point; a divider that is off by one or a wrap that is handled wrongly shifts those counts. It changes the fall point partway through a cycle in both update modes. A design that ignores the wrap boundary would shorten or stretch the pulse in progress when synchronization is on, and a design that always waits for the wrap would miss the immediate change. Equal compare points, a missing enable, watchdog events with the load disabled, and both fallback targets are also run. A wrong priority between the points would show a pulse, and a target swap would change the measured active time.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
   localparam int PT_W = 8;

   typedef struct packed {
      logic [PT_W-1:0] per;
      logic [PT_W-1:0] alt;
      logic [PT_W-1:0] fall;
      logic [PT_W-1:0] rise;
   } fpwm_duty_t;
endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale #(
   parameter int EXP_W = 4,
   parameter int LIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [EXP_W-1:0] exp_code,
   input  logic [LIN_W-1:0] lin_code,
   output logic             tick
);
   localparam int EXP_CNT_W = (1 << EXP_W) - 1;

   logic [EXP_CNT_W-1:0] e_cnt, e_lim;
   logic [LIN_W-1:0]     l_cnt;
   logic                 e_tick;

   // the limit is 2^n - 1: a mask of n low ones
   assign e_lim  = ~({EXP_CNT_W{1'b1}} << exp_code);
   assign e_tick = en && (e_cnt >= e_lim);
   assign tick   = e_tick && (l_cnt >= lin_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      e_cnt <= '0;
      else if (!en)    e_cnt <= '0;
      else if (e_tick) e_cnt <= '0;
      else             e_cnt <= e_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      l_cnt <= '0;
      else if (!en)    l_cnt <= '0;
      else if (tick)   l_cnt <= '0;
      else if (e_tick) l_cnt <= l_cnt + 1'b1;
   end
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core
   import fpwm_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic            sync_dis,
   input  logic            wd_en,
   input  logic            wd_sel,
   input  logic            wd_evt,
   input  logic [31:0]     duty_i,
   output logic [PT_W-1:0] cnt_o,
   output logic [PT_W-1:0] per_o,
   output logic [PT_W-1:0] rise_o,
   output logic [PT_W-1:0] fall_o,
   output logic            wave_o
);
   fpwm_duty_t      d;
   logic [PT_W-1:0] cnt_q, per_q, rise_q, fall_q, alt_q;
   logic            wd_hit, wrap, load;

   assign d    = fpwm_duty_t'(duty_i);
   assign wrap = tick && (cnt_q >= per_q);
   assign load = !en || sync_dis || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en)   cnt_q <= '0;
      else if (wrap)  cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   // the duty input acts as the shadow copy; the active set follows it at load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (load) begin
         per_q  <= d.per;
         rise_q <= d.rise;
         fall_q <= d.fall;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_hit <= 1'b0;
         alt_q  <= '0;
      end else if (!en) begin
         wd_hit <= 1'b0;
      end else if (wd_en && wd_evt) begin
         wd_hit <= 1'b1;
         alt_q  <= d.alt;
      end
   end

   assign rise_o = (wd_hit && !wd_sel) ? alt_q : rise_q;
   assign fall_o = (wd_hit &&  wd_sel) ? alt_q : fall_q;

   // fall compare has priority so equal points give an idle cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wave_o <= 1'b0;
      else if (!en)              wave_o <= 1'b0;
      else if (cnt_q == fall_o)  wave_o <= 1'b0;
      else if (cnt_q == rise_o)  wave_o <= 1'b1;
   end

   assign cnt_o = cnt_q;
   assign per_o = per_q;
endmodule

// File: rtl/fan_pwm_chan.sv
module fan_pwm_chan
   import fpwm_pkg::*;
#(
   parameter int EXP_W   = 4,
   parameter int LIN_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      cfg_duty,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic [LIN_W-1:0] cfg_lin,
   input  logic             cfg_clk_en,
   input  logic             cfg_pin_en,
   input  logic             cfg_inv,
   input  logic             cfg_od,
   input  logic             cfg_force,
   input  logic             cfg_sync_dis,
   input  logic             cfg_wd_en,
   input  logic             cfg_wd_sel,
   input  logic             wd_evt,
   output logic             pwm_o,
   output logic             pwm_oe
);
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("fan_pwm_chan: EXP_W out of range");
   end
   if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
      $error("fan_pwm_chan: LIN_W out of range");
   end

   logic            chan_en, pre_tick, wave_q, lvl_d;
   logic [PT_W-1:0] cnt_q, per_act, rise_act, fall_act;

   assign chan_en = cfg_clk_en & cfg_pin_en;

   fpwm_prescale #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .exp_code (cfg_exp),
      .lin_code (cfg_lin),
      .tick     (pre_tick)
   );

   fpwm_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .tick     (pre_tick),
      .sync_dis (cfg_sync_dis),
      .wd_en    (cfg_wd_en),
      .wd_sel   (cfg_wd_sel),
      .wd_evt   (wd_evt),
      .duty_i   (cfg_duty),
      .cnt_o    (cnt_q),
      .per_o    (per_act),
      .rise_o   (rise_act),
      .fall_o   (fall_act),
      .wave_o   (wave_q)
   );

   assign lvl_d = cfg_inv ^ (chan_en & (cfg_force | wave_q));

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_o <= 1'b0;
         else        pwm_o <= lvl_d;
      end
   end else begin : g_out_comb
      assign pwm_o = lvl_d;
   end

   assign pwm_oe = ~cfg_od | ~pwm_o;
endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk
   import fpwm_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            tick,
   input logic            sync_dis,
   input logic [PT_W-1:0] cnt,
   input logic [PT_W-1:0] per,
   input logic [PT_W-1:0] rise,
   input logic [PT_W-1:0] fall,
   input logic            wave
);
   logic wrap;
   assign wrap = tick && (cnt >= per);

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt)); // R2
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sync_dis && $past(!sync_dis)) |-> (cnt <= per)); // R3
   AST_EQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rise == fall && cnt == fall) |=> !wave); // R4
   AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0 && !wave)); // R5
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sync_dis && !wrap) |=> $stable(per)); // R7
endmodule

bind fan_pwm_chan fpwm_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (chan_en),
   .tick     (pre_tick),
   .sync_dis (cfg_sync_dis),
   .cnt      (cnt_q),
   .per      (per_act),
   .rise     (rise_act),
   .fall     (fall_act),
   .wave     (wave_q)
);

// File: tb/fan_pwm_chan_tb.sv
module fan_pwm_chan_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_duty = '0;
   logic [3:0]  cfg_exp = '0;
   logic [7:0]  cfg_lin = '0;
   logic        clk_en = 0, pin_en = 0, inv = 0, od = 0, force_hi = 0;
   logic        sync_dis = 0, wd_en = 0, wd_sel = 0, wd_evt = 0;
   logic        pwm_o, pwm_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   fan_pwm_chan u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty), .cfg_exp(cfg_exp),
      .cfg_lin(cfg_lin), .cfg_clk_en(clk_en), .cfg_pin_en(pin_en),
      .cfg_inv(inv), .cfg_od(od), .cfg_force(force_hi),
      .cfg_sync_dis(sync_dis), .cfg_wd_en(wd_en), .cfg_wd_sel(wd_sel),
      .wd_evt(wd_evt), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
   );

   typedef struct { int hi; int pd; string tag; } exp_t;
   exp_t sb_q[$];
   int   checks = 0, errors = 0;
   logic arm = 0, mon_inv = 0;

   // monitor: measures active and period time between active-edge starts
   initial begin : mon
      logic prv, cur;
      int   hi, pd;
      bit   started;
      exp_t e;
      prv = 0; hi = 0; pd = 0; started = 0;
      forever begin
         @(negedge clk);
         cur = pwm_o ^ mon_inv;
         if (!arm) started = 0;
         else begin
            if (cur && !prv) begin
               if (started && sb_q.size() > 0) begin
                  e = sb_q.pop_front();
                  checks++;
                  if (hi != e.hi || pd != e.pd) begin
                     errors++;
                     $display("FAIL %s: high/period %0d/%0d, expected %0d/%0d",
                              e.tag, hi, pd, e.hi, e.pd);
                  end
               end
               started = 1; hi = 0; pd = 0;
            end
            if (started) begin
               pd++;
               if (cur) hi++;
            end
         end
         prv = cur;
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
      end
   endtask

   task automatic setup(int e, int l, int per, int rise, int fall, int alt = 0);
      clk_en = 0; pin_en = 0;
      step(2);
      cfg_exp = e[3:0]; cfg_lin = l[7:0];
      cfg_duty = {per[7:0], alt[7:0], fall[7:0], rise[7:0]};
      step(1);
      clk_en = 1; pin_en = 1;
   endtask

   task automatic push(string tag, int hi, int pd, int n);
      exp_t e;
      e.hi = hi; e.pd = pd; e.tag = tag;
      repeat (n) sb_q.push_back(e);
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 20000 && sb_q.size() > 0; i++) step(1);
      if (sb_q.size() > 0) begin
         checks++; errors++;
         $display("FAIL %s: %0d pulses missing, expected 0", tag, sb_q.size());
         sb_q.delete();
      end
      arm = 0;
      step(1);
   endtask

   task automatic run(string tag, int hi, int pd, int n);
      push(tag, hi, pd, n);
      arm = 1;
      drain(tag);
   endtask

   task automatic watch(int n, output int rises, output int highs);
      logic p;
      rises = 0; highs = 0; p = pwm_o;
      for (int i = 0; i < n; i++) begin
         step(1);
         if (pwm_o && !p) rises++;
         if (pwm_o) highs++;
         p = pwm_o;
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : drive
      int r, h, mism, seen;
      step(3);
      chk(pwm_o == 1'b0, "R11 pwm_o in reset", pwm_o, 0);
      rst_n = 1;
      step(2);
      chk(pwm_o == 1'b0, "R11 pwm_o after reset", pwm_o, 0);
      chk(pwm_oe == 1'b1, "R11 pwm_oe after reset", pwm_oe, 1);

      // R3 basic duty, divide by 1
      setup(0, 0, 9, 0, 4);
      run("R3 rise0 fall4 per9", 4, 10, 3);
      // R1 power-of-two stage
      setup(2, 0, 9, 0, 4);
      run("R1 exp code 2", 16, 40, 2);
      // R2 cascade and largest linear code
      setup(2, 2, 4, 1, 3);
      run("R2 exp2 lin2", 24, 60, 2);
      setup(0, 255, 1, 0, 1);
      run("R2 lin code 0xFF", 256, 512, 2);
      // R3 rise after fall wraps across the cycle end
      setup(1, 0, 7, 5, 2);
      run("R3 wrap-around pulse", 10, 16, 2);

      // R4 equal points
      setup(0, 0, 9, 3, 3);
      step(3);
      watch(40, r, h);
      chk(r == 0 && h == 0, "R4 equal points idle", h, 0);

      // R5 pin enable missing
      setup(0, 0, 9, 0, 4);
      pin_en = 0;
      step(3);
      watch(40, r, h);
      chk(r == 0 && h == 0, "R5 pin enable low", h, 0);
      inv = 1;
      step(3);
      watch(20, r, h);
      chk(h == 20, "R5 disabled inverted rest level", h, 20);

      // R6 inversion
      setup(0, 0, 9, 0, 4);
      mon_inv = 1;
      run("R6 inverted pulses", 4, 10, 2);
      mon_inv = 0; inv = 0;
      // R6 open drain enable
      od = 1;
      setup(0, 0, 9, 0, 4);
      mism = 0; seen = 0;
      for (int i = 0; i < 30; i++) begin
         step(1);
         if (pwm_oe != !pwm_o) mism++;
         if (pwm_o) seen++;
      end
      chk(mism == 0 && seen > 0, "R6 open-drain enable", mism, 0);
      od = 0;
      mism = 0;
      for (int i = 0; i < 30; i++) begin
         step(1);
         if (pwm_oe != 1'b1) mism++;
      end
      chk(mism == 0, "R6 push-pull enable", mism, 0);

      // R9 forced level
      force_hi = 1;
      setup(0, 0, 9, 0, 4);
      step(3);
      watch(30, r, h);
      chk(h == 30, "R9 forced active level", h, 30);
      force_hi = 0;

      // R7 synchronized update waits for wrap
      setup(0, 0, 9, 0, 4);
      push("R7 old fall kept", 4, 10, 1);
      push("R7 new fall after wrap", 7, 10, 2);
      arm = 1;
      @(posedge pwm_o); #1;
      cfg_duty[15:8] = 8'd7;
      drain("R7");

      // R8 unsynchronized update is immediate
      sync_dis = 1;
      setup(0, 0, 9, 0, 4);
      push("R8 immediate fall", 7, 10, 2);
      arm = 1;
      @(posedge pwm_o); #1;
      cfg_duty[15:8] = 8'd7;
      drain("R8");
      sync_dis = 0;

      // R10 watchdog load replaces fall point
      wd_en = 0; wd_sel = 1;
      setup(0, 0, 9, 0, 4, 7);
      wd_evt = 1; step(1); wd_evt = 0;
      step(12);
      run("R10 event ignored when disabled", 4, 10, 2);
      wd_en = 1;
      wd_evt = 1; step(1); wd_evt = 0;
      step(12);
      run("R10 fallback fall point", 7, 10, 2);
      // R10 watchdog load replaces rise point
      wd_sel = 0;
      setup(0, 0, 9, 0, 6, 2);
      run("R10 before event", 6, 10, 1);
      wd_evt = 1; step(1); wd_evt = 0;
      step(12);
      run("R10 fallback rise point", 4, 10, 2);
      wd_en = 0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule